// File: doc/BRIEF.md
# Programmable performance event counter

This block is a single performance monitoring counter with its own event-select control word. An external event source reports, every clock, how many occurrences of the selected event it saw. The block also sees the current privilege level. It decides per cycle whether and by how much to advance a 40-bit counter. That decision depends on an enable bit, a pair of privilege qualifiers, a count threshold that can be inverted, and an optional rising-edge filter.

When the counter wraps past its all-ones value, a sticky overflow flag is set. That flag, gated by an interrupt-enable bit, drives an interrupt request. An optional pin-control output shows when the qualified condition holds.

Software reaches the block through a simple single-cycle write and combinational read port. Address 0 is the control word, address 1 is the counter and address 2 is the overflow status. The event-select and unit-mask fields are not decoded here. They are held and handed to the event source.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the control word, the counter, the overflow flag, the interrupt output and the pin output all read zero.
- R2: A write to address 0 stores bits 31:0 of the data into the control word. Reading address 0 returns the stored word with bit 21 and bits 63:32 as zero. Bits 7:0 (event select) appear on `evt_sel` and bits 15:8 (unit mask) appear on `unit_mask`. Address 3 reads zero.
- R3: While control bit 22 (enable) is 0, the counter does not change except by a software load.
- R4: Privilege qualification works as follows. When `priv_ring0` is 1, counting requires control bit 17. When `priv_ring0` is 0, counting requires control bit 16.
- R5: With the threshold field (bits 31:24) equal to zero, a qualifying cycle adds the raw `evt_count` to the counter. The condition is true when `evt_count` is non-zero.
- R6: With a non-zero threshold and bit 23 clear, the counter advances by one on each cycle where `evt_count` ≥ threshold.
- R7: With a non-zero threshold and bit 23 set, the counter advances by one on each cycle where `evt_count` < threshold.
- R8: With bit 18 (edge) set, the counter advances by exactly one only in a cycle whose qualified condition is true while it was false in the previous cycle.
- R9: A write to address 1 loads bits 39:0 into the counter, and this load overrides any increment in the same cycle. A wrap from all ones to zero sets the overflow flag, which reads as bit 0 at address 2. The flag stays set until a write to address 2 with data bit 0 = 1 clears it, and a wrap in the same cycle wins over the clear.
- R10: `irq` equals the overflow flag ANDed with control bit 20.
- R11: With control bit 19 set, `pmon_pin` is high in the cycle after a clock edge whose cycle had a true qualified condition. With bit 19 clear, `pmon_pin` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 counter, 2 status |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| evt_count | input | 8 | Per-cycle event count from the event source |
| priv_ring0 | input | 1 | 1 when the current privilege level is ring 0 |
| evt_sel | output | 8 | Held event-select field |
| unit_mask | output | 8 | Held unit-mask field |
| pmon_pin | output | 1 | Qualified-condition pin, registered |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench sweeps the full 8-bit event-count range against thresholds of zero, one, a mid value and the maximum, with and without inversion. A design that mishandles the comparison boundary, by using > instead of ≥ or by inverting at the wrong point, ends each sweep with a total that is off. All eight privilege and ring combinations are swept. A swapped kernel/user bit counts in exactly the wrong runs.

Edge mode is driven with bursts of non-zero counts separated by zero gaps. A design that counts levels rather than rising edges, or that adds the raw count in edge mode, overshoots the expected total.

At the top of the counter, the bench checks three cases. A wrap must set the sticky flag. A clear written in the same cycle as a wrap must lose. A load must beat a concurrent increment.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Control word, bit 31 first; field positions are software visible.
    typedef struct packed {
        logic [7:0] thresh;   // 31:24
        logic       invert;   // 23
        logic       enable;   // 22
        logic       spare;    // 21, always held at zero
        logic       irq_en;   // 20
        logic       pin_en;   // 19
        logic       edge_en;  // 18
        logic       kern_en;  // 17
        logic       user_en;  // 16
        logic [7:0] umask;    // 15:8
        logic [7:0] evsel;    // 7:0
    } pmc_ctl_t;

    localparam int CTL_W = $bits(pmc_ctl_t);

    typedef enum logic [1:0] {
        A_CTL  = 2'd0,
        A_CNT  = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } pmc_addr_e;

endpackage

// File: rtl/pmc_ctl_reg.sv
module pmc_ctl_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output pmc_ctl_t         ctl_q
);

    pmc_ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d       = pmc_ctl_t'(wdata);
            ctl_d.spare = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/pmc_qualify.sv
module pmc_qualify #(
    parameter int EVC_W = 8
) (
    input  logic [EVC_W-1:0] evt_count,
    input  logic             ring0,
    input  logic [7:0]       thresh,
    input  logic             invert,
    input  logic             enable,
    input  logic             kern_en,
    input  logic             user_en,
    output logic             qual,
    output logic [EVC_W-1:0] step
);

    localparam int CMP_W = (EVC_W > 8) ? EVC_W : 8;

    logic [CMP_W-1:0] evt_ext;
    logic [CMP_W-1:0] thr_ext;
    logic             thr_nz;
    logic             below;
    logic             priv_ok;
    logic             cond;

    always_comb begin
        evt_ext = CMP_W'(evt_count);
        thr_ext = CMP_W'(thresh);
        thr_nz  = (thresh != 8'd0);
        below   = (evt_ext < thr_ext);
        priv_ok = ring0 ? kern_en : user_en;
        if (thr_nz) cond = invert ? below : !below;
        else        cond = (evt_count != '0);
        qual = enable && priv_ok && cond;
        step = thr_nz ? EVC_W'(1) : evt_count;
    end

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
    parameter int CNT_W = 40,
    parameter int EVC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    input  logic [EVC_W-1:0] step,
    input  logic             edge_en,
    input  logic             pin_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             pin_q
);

    localparam int PAD_W = CNT_W + 1 - EVC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             prev;
        logic             pin;
    } acc_t;

    acc_t         st_d;
    acc_t         st_q;
    logic [CNT_W:0] add;
    logic [CNT_W:0] sum;
    logic           carry;

    always_comb begin
        if (edge_en) add = (qual && !st_q.prev) ? (CNT_W+1)'(1) : '0;
        else         add = qual ? {{PAD_W{1'b0}}, step} : '0;
        sum   = {1'b0, st_q.cnt} + add;
        carry = !load && sum[CNT_W];

        st_d.cnt  = load ? load_val : sum[CNT_W-1:0];
        st_d.ovf  = carry || (st_q.ovf && !ovf_clr);
        st_d.prev = qual;
        st_d.pin  = pin_en && qual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign ovf_q = st_q.ovf;
    assign pin_q = st_q.pin;

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
    import pmc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int EVC_W  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVC_W-1:0]  evt_count,
    input  logic              priv_ring0,
    output logic [7:0]        evt_sel,
    output logic [7:0]        unit_mask,
    output logic              pmon_pin,
    output logic              irq
);

    pmc_ctl_t         ctl_q;
    logic             qual;
    logic [EVC_W-1:0] step;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             pin_q;
    logic             wr_ctl;
    logic             wr_cnt;
    logic             wr_clr;
    logic             unused_hi;

    assign wr_ctl    = reg_wr && (reg_addr == A_CTL);
    assign wr_cnt    = reg_wr && (reg_addr == A_CNT);
    assign wr_clr    = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
    assign unused_hi = ^reg_wdata[DATA_W-1:CNT_W];

    pmc_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ctl),
        .wdata (reg_wdata[CTL_W-1:0]),
        .ctl_q (ctl_q)
    );

    pmc_qualify #(.EVC_W(EVC_W)) u_qual (
        .evt_count (evt_count),
        .ring0     (priv_ring0),
        .thresh    (ctl_q.thresh),
        .invert    (ctl_q.invert),
        .enable    (ctl_q.enable),
        .kern_en   (ctl_q.kern_en),
        .user_en   (ctl_q.user_en),
        .qual      (qual),
        .step      (step)
    );

    pmc_accum #(.CNT_W(CNT_W), .EVC_W(EVC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .step     (step),
        .edge_en  (ctl_q.edge_en),
        .pin_en   (ctl_q.pin_en),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .ovf_clr  (wr_clr),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q),
        .pin_q    (pin_q)
    );

    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
            A_CNT:   reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            A_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, ovf_q};
            default: reg_rdata = '0;
        endcase
    end

    assign evt_sel   = ctl_q.evsel;
    assign unit_mask = ctl_q.umask;
    assign pmon_pin  = pin_q;
    assign irq       = ovf_q && ctl_q.irq_en;

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wbit0,
    input logic             c_enable,
    input logic             c_edge,
    input logic             c_pin,
    input logic [7:0]       c_thresh,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q,
    input logic             irq,
    input logic             pmon_pin
);

    logic ld;
    logic clr;
    assign ld  = reg_wr && (reg_addr == 2'd1);
    assign clr = reg_wr && (reg_addr == 2'd2) && wbit0;

    AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_enable && !ld) |=> $stable(cnt_q)); // R3

    AST_THRESH_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_thresh != 8'd0) && !ld) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R6

    AST_EDGE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_edge && !ld) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q); // R9

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_q); // R10

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pmon_pin) |-> $past(c_pin)); // R11

endmodule

bind perf_event_counter pmc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .c_enable (ctl_q.enable),
    .c_edge   (ctl_q.edge_en),
    .c_pin    (ctl_q.pin_en),
    .c_thresh (ctl_q.thresh),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_q),
    .irq      (irq),
    .pmon_pin (pmon_pin)
);

// File: tb/tb_perf_event_counter.sv
`timescale 1ns/1ps
module tb_perf_event_counter;

    localparam logic [31:0] B_USR  = 32'h0001_0000;
    localparam logic [31:0] B_KRN  = 32'h0002_0000;
    localparam logic [31:0] B_EDGE = 32'h0004_0000;
    localparam logic [31:0] B_PIN  = 32'h0008_0000;
    localparam logic [31:0] B_INT  = 32'h0010_0000;
    localparam logic [31:0] B_EN   = 32'h0040_0000;
    localparam logic [31:0] B_INV  = 32'h0080_0000;
    localparam logic [63:0] TOP    = 64'h0000_00FF_FFFF_FFFF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [63:0] reg_wdata = 0;
    logic [63:0] reg_rdata;
    logic [7:0]  evt_count = 0;
    logic        priv_ring0 = 0;
    logic [7:0]  evt_sel;
    logic [7:0]  unit_mask;
    logic        pmon_pin;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    perf_event_counter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_count(evt_count),
        .priv_ring0(priv_ring0), .evt_sel(evt_sel), .unit_mask(unit_mask),
        .pmon_pin(pmon_pin), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    // Requirement-level model of one cycle.
    task automatic model(input logic [31:0] c, input int e, input bit r0,
                         inout bit prev, output longint inc, output bit q);
        int thr;
        bit cond;
        bit priv;
        thr  = int'(c[31:24]);
        priv = r0 ? c[17] : c[16];
        if (thr != 0) cond = c[23] ? (e < thr) : (e >= thr);
        else          cond = (e != 0);
        q = c[22] && priv && cond;
        if (c[18]) inc = (q && !prev) ? 1 : 0;
        else       inc = q ? ((thr != 0) ? 1 : e) : 0;
        prev = q;
    endtask

    task automatic sweep(input string req, input logic [31:0] c, input bit r0,
                         input int mul, input int add, input int gap);
        longint exp;
        longint inc;
        bit prev;
        bit q;
        int pin_bad;
        logic [63:0] v;
        evt_count = 0;
        priv_ring0 = r0;
        wr(2'd0, 64'd0);
        wr(2'd1, 64'd0);
        wr(2'd0, {32'd0, c});
        exp = 0; prev = 0; pin_bad = 0;
        for (int i = 0; i < 256; i++) begin
            int e;
            e = (i * mul + add) % 256;
            if (gap > 0 && ((i / gap) % 2) == 1) e = 0;
            evt_count = e[7:0];
            @(negedge clk);
            model(c, e, r0, prev, inc, q);
            exp += inc;
            if (pmon_pin !== (c[19] && q)) pin_bad++;
        end
        evt_count = 0;
        rd(2'd1, v);
        chk(req, v, exp[63:0]);
        chk("R11 pin trace", 64'(pin_bad), 64'd0);
    endtask

    initial begin
        logic [63:0] v;
        priv_ring0 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctl", v, 64'd0);
        rd(2'd1, v); chk("R1 cnt", v, 64'd0);
        rd(2'd2, v); chk("R1 flag", v, 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 pin", 64'(pmon_pin), 64'd0);

        // R2 control storage, reserved bits, field outputs
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); chk("R2 ctl all-ones", v, 64'h0000_0000_FFDF_FFFF);
        chk("R2 evt_sel", 64'(evt_sel), 64'hFF);
        chk("R2 unit_mask", 64'(unit_mask), 64'hFF);
        wr(2'd0, 64'h1234_5678_0A1B_5AC3);
        rd(2'd0, v); chk("R2 ctl pattern", v, 64'h0000_0000_0A1B_5AC3);
        chk("R2 evt_sel pattern", 64'(evt_sel), 64'hC3);
        chk("R2 unit_mask pattern", 64'(unit_mask), 64'h5A);
        rd(2'd3, v); chk("R2 addr3", v, 64'd0);

        // R3 disabled
        sweep("R3 enable clear", B_USR | B_KRN | B_PIN, 1'b0, 1, 0, 0);
        // R5 raw add
        sweep("R5 raw ramp", B_EN | B_USR | B_PIN, 1'b0, 1, 0, 0);
        sweep("R5 raw scrambled", B_EN | B_KRN, 1'b1, 37, 11, 0);
        // R6 thresholds
        sweep("R6 thr 1", B_EN | B_USR | B_PIN | 32'h0100_0000, 1'b0, 1, 0, 0);
        sweep("R6 thr 5", B_EN | B_USR | 32'h0500_0000, 1'b0, 1, 0, 0);
        sweep("R6 thr 255", B_EN | B_USR | 32'hFF00_0000, 1'b0, 1, 0, 0);
        // R7 inverted
        sweep("R7 inv thr 5", B_EN | B_USR | B_INV | B_PIN | 32'h0500_0000, 1'b0, 1, 0, 0);
        sweep("R7 inv thr 255", B_EN | B_USR | B_INV | 32'hFF00_0000, 1'b0, 1, 0, 0);
        // R4 privilege combinations
        for (int k = 0; k < 8; k++) begin
            logic [31:0] c;
            c = B_EN | (k[0] ? B_USR : 32'd0) | (k[1] ? B_KRN : 32'd0);
            sweep("R4 privilege", c, k[2], 3, 1, 0);
        end
        // R8 edge detection
        sweep("R8 edge raw bursts", B_EN | B_USR | B_EDGE | B_PIN, 1'b0, 7, 3, 4);
        sweep("R8 edge inv thr", B_EN | B_KRN | B_EDGE | B_INV | 32'h6400_0000, 1'b1, 13, 0, 0);
        sweep("R8 edge thr gaps", B_EN | B_USR | B_EDGE | 32'h0200_0000, 1'b0, 1, 0, 3);

        // R9/R10 overflow
        evt_count = 0; priv_ring0 = 0;
        wr(2'd0, {32'd0, B_EN | B_USR | B_INT});
        wr(2'd1, TOP - 64'd2);
        evt_count = 8'd5;
        @(negedge clk);
        evt_count = 0;
        rd(2'd1, v); chk("R9 wrap value", v, 64'd2);
        rd(2'd2, v); chk("R9 flag set", v, 64'd1);
        chk("R10 irq on", 64'(irq), 64'd1);
        wr(2'd0, {32'd0, B_EN | B_USR});
        chk("R10 irq masked", 64'(irq), 64'd0);
        rd(2'd2, v); chk("R9 flag kept", v, 64'd1);
        wr(2'd2, 64'd0);
        rd(2'd2, v); chk("R9 write zero no clear", v, 64'd1);
        wr(2'd2, 64'd1);
        rd(2'd2, v); chk("R9 flag cleared", v, 64'd0);
        wr(2'd1, TOP);
        evt_count = 8'd1;
        wr(2'd2, 64'd1);
        evt_count = 0;
        rd(2'd2, v); chk("R9 set beats clear", v, 64'd1);
        rd(2'd1, v); chk("R9 wrap to zero", v, 64'd0);
        evt_count = 8'd50;
        wr(2'd1, 64'd1234);
        evt_count = 0;
        rd(2'd1, v); chk("R9 load beats increment", v, 64'd1234);
        wr(2'd0, {32'd0, B_EN | B_USR | B_INT});
        chk("R10 irq re-enabled", 64'(irq), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule